// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside the ECC checker of a DRAM controller and keeps the software-visible record of memory errors. The checker raises single-cycle event pulses for correctable and uncorrectable errors. Each pulse comes with the failing 4 KiB block address, an 8-bit syndrome and the channel number. The block sets sticky status flags. It captures the error details under fixed priority rules and raises a registered system-error output when a set flag has its enable bit on.

Software reads and writes the registers through a plain register port that uses byte offsets. The status flags clear only when software writes a one to them. An uncorrectable error replaces the details of a correctable error that has not yet been cleared, but the two flags stay separate. The status register also holds seven non-ECC event flags, and these behave as plain sticky write-one-to-clear bits.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every mapped register reads zero and `serr_o` is low.
- R2: The status register is at offset 0xC8. The correctable flag is bit 0 and the uncorrectable flag is bit 7. `aux_evt[4:0]` set bits 5:1 and `aux_evt[6:5]` set bits 9:8. Bits 15:10 and bit 6 always read zero.
- R3: A write to 0xC8 clears each status bit whose data bit is 1 and leaves the other bits unchanged. Writing 0x0081 clears both ECC flags.
- R4: When a new event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A correctable event that arrives while neither ECC flag is set captures its block address, syndrome and channel.
- R6: A correctable event that arrives while either ECC flag is set only sets its flag. The captured address, syndrome and channel do not change.
- R7: An uncorrectable event that arrives while the uncorrectable flag is clear captures its own details, even over a pending correctable capture. If both events arrive in the same cycle, the uncorrectable details are kept.
- R8: An uncorrectable event that arrives while the uncorrectable flag is set leaves the captured details unchanged.
- R9: The address register at 0x58 returns the block address in bits 31:12, with bits 11:0 reading zero. The syndrome reads at 0x5C in bits 7:0. The channel reads at 0x5D in bit 0, with bits 7:1 reading zero.
- R10: The command register at 0xCA stores data bits 9:1. Bit 0 and bits 15:10 read zero.
- R11: `serr_o` goes high one clock after a cycle in which (status bit 0 AND command bit 7) OR (status bit 7 AND command bit 8) holds. Otherwise it is low.
- R12: Writes to any offset other than 0xC8 and 0xCA have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error pulse |
| ce_blk | input | 20 | Correctable error block address (address bits 31:12) |
| ce_syn | input | 8 | Correctable error syndrome |
| ce_chan | input | 1 | Correctable error channel |
| ue_evt | input | 1 | Uncorrectable error pulse |
| ue_blk | input | 20 | Uncorrectable error block address (address bits 31:12) |
| ue_syn | input | 8 | Uncorrectable error syndrome |
| ue_chan | input | 1 | Uncorrectable error channel |
| aux_evt | input | 7 | Non-ECC event pulses |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| serr_o | output | 1 | Registered system-error output |

## Verification
The hardest cases to reach are the collisions: a correctable capture overwritten by an uncorrectable one, both kinds of event in the same cycle, and a clearing write that lands in the same cycle as a new event on the same flag. The stimulus builds each of these on purpose. It leaves a correctable error pending and then sends an uncorrectable one. It pulses both events together. It drives a write-one-to-clear and an event pulse on the same clock. A behavioural model compares the read data and `serr_o` on every clock throughout.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int REG_AW  = 8;
    localparam int REG_DW  = 32;
    localparam int WR_DW   = 16;
    localparam int ADDR_W  = 32;
    localparam int GRAN    = 12;
    localparam int BLK_W   = ADDR_W - GRAN;
    localparam int SYN_W   = 8;
    localparam int AUX_W   = 7;
    localparam int STS_W   = 16;

    localparam logic [REG_AW-1:0] OFS_ADDR = 8'h58;
    localparam logic [REG_AW-1:0] OFS_SYN  = 8'h5C;
    localparam logic [REG_AW-1:0] OFS_CHAN = 8'h5D;
    localparam logic [REG_AW-1:0] OFS_STS  = 8'hC8;
    localparam logic [REG_AW-1:0] OFS_CMD  = 8'hCA;

    localparam int BIT_CE = 0;
    localparam int BIT_UE = 7;
    localparam int EN_CE  = 7;
    localparam int EN_UE  = 8;

    localparam logic [STS_W-1:0] STS_IMPL = 16'h03BF;
    localparam logic [STS_W-1:0] CMD_IMPL = 16'h03FE;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [STS_W-1:0] cmd;
        logic             serr;
    } ctl_t;

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [SYN_W-1:0] syn;
        logic             chan;
    } cap_t;

    // status bit fed by non-ECC event i: 1..5, then 8..9
    function automatic int aux_pos(input int i);
        return (i < 5) ? i + 1 : i + 3;
    endfunction
endpackage

// File: rtl/ecc_cap_decode.sv
module ecc_cap_decode
    import ecc_cap_pkg::*;
(
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WR_DW-1:0]  reg_wdata,
    output logic [STS_W-1:0]  sts_clr,
    output logic              cmd_we,
    output logic [STS_W-1:0]  cmd_wdata
);
    always_comb begin
        sts_clr   = (reg_wen && reg_addr == OFS_STS) ? reg_wdata : '0;
        cmd_we    = reg_wen && (reg_addr == OFS_CMD);
        cmd_wdata = reg_wdata;
    end
endmodule

// File: rtl/ecc_cap_status.sv
module ecc_cap_status
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_evt,
    input  logic             ue_evt,
    input  logic [AUX_W-1:0] aux_evt,
    input  logic [STS_W-1:0] sts_clr,
    input  logic             cmd_we,
    input  logic [STS_W-1:0] cmd_wdata,
    output logic [STS_W-1:0] sts_q,
    output logic [STS_W-1:0] cmd_q,
    output logic             serr_q
);
    ctl_t ctl_d, ctl_q;
    logic [STS_W-1:0] set_d;

    always_comb begin
        set_d = '0;
        for (int i = 0; i < AUX_W; i++) begin
            set_d[aux_pos(i)] = aux_evt[i];
        end
        set_d[BIT_CE] = ce_evt;
        set_d[BIT_UE] = ue_evt;

        ctl_d      = ctl_q;
        ctl_d.serr = (ctl_q.sts[BIT_CE] & ctl_q.cmd[EN_CE])
                   | (ctl_q.sts[BIT_UE] & ctl_q.cmd[EN_UE]);
        ctl_d.sts  = ((ctl_q.sts & ~sts_clr) | set_d) & STS_IMPL;
        if (cmd_we) begin
            ctl_d.cmd = cmd_wdata & CMD_IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sts_q  = ctl_q.sts;
    assign cmd_q  = ctl_q.cmd;
    assign serr_q = ctl_q.serr;
endmodule

// File: rtl/ecc_cap_record.sv
module ecc_cap_record
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_evt,
    input  logic [BLK_W-1:0] ce_blk,
    input  logic [SYN_W-1:0] ce_syn,
    input  logic             ce_chan,
    input  logic             ue_evt,
    input  logic [BLK_W-1:0] ue_blk,
    input  logic [SYN_W-1:0] ue_syn,
    input  logic             ue_chan,
    input  logic             ce_pend,
    input  logic             ue_pend,
    output cap_t             cap_q
);
    cap_t cap_d, rec_q;

    always_comb begin
        cap_d = rec_q;
        if (ue_evt && !ue_pend) begin
            cap_d.blk  = ue_blk;
            cap_d.syn  = ue_syn;
            cap_d.chan = ue_chan;
        end else if (ce_evt && !ue_evt && !ce_pend && !ue_pend) begin
            cap_d.blk  = ce_blk;
            cap_d.syn  = ce_syn;
            cap_d.chan = ce_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= cap_d;
    end

    assign cap_q = rec_q;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_evt,
    input  logic [BLK_W-1:0]  ce_blk,
    input  logic [SYN_W-1:0]  ce_syn,
    input  logic              ce_chan,
    input  logic              ue_evt,
    input  logic [BLK_W-1:0]  ue_blk,
    input  logic [SYN_W-1:0]  ue_syn,
    input  logic              ue_chan,
    input  logic [AUX_W-1:0]  aux_evt,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WR_DW-1:0]  reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              serr_o
);
    logic [STS_W-1:0] sts_clr, cmd_wdata, sts_q, cmd_q;
    logic             cmd_we;
    cap_t             cap_q;
    logic [BLK_W-1:0] cap_blk;

    ecc_cap_decode u_dec (
        .reg_wen  (reg_wen),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sts_clr  (sts_clr),
        .cmd_we   (cmd_we),
        .cmd_wdata(cmd_wdata)
    );

    ecc_cap_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_evt   (ce_evt),
        .ue_evt   (ue_evt),
        .aux_evt  (aux_evt),
        .sts_clr  (sts_clr),
        .cmd_we   (cmd_we),
        .cmd_wdata(cmd_wdata),
        .sts_q    (sts_q),
        .cmd_q    (cmd_q),
        .serr_q   (serr_o)
    );

    ecc_cap_record u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_evt (ce_evt),
        .ce_blk (ce_blk),
        .ce_syn (ce_syn),
        .ce_chan(ce_chan),
        .ue_evt (ue_evt),
        .ue_blk (ue_blk),
        .ue_syn (ue_syn),
        .ue_chan(ue_chan),
        .ce_pend(sts_q[BIT_CE]),
        .ue_pend(sts_q[BIT_UE]),
        .cap_q  (cap_q)
    );

    assign cap_blk = cap_q.blk;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ADDR: reg_rdata = {cap_q.blk, {GRAN{1'b0}}};
            OFS_SYN:  reg_rdata[SYN_W-1:0] = cap_q.syn;
            OFS_CHAN: reg_rdata[0] = cap_q.chan;
            OFS_STS:  reg_rdata[STS_W-1:0] = sts_q;
            OFS_CMD:  reg_rdata[STS_W-1:0] = cmd_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk
    import ecc_cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ce_evt,
    input logic              ue_evt,
    input logic [BLK_W-1:0]  ue_blk,
    input logic [STS_W-1:0]  sts_q,
    input logic [STS_W-1:0]  cmd_q,
    input logic [BLK_W-1:0]  cap_blk,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              serr_o
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STS) |-> (reg_rdata[15:10] == 6'd0 && !reg_rdata[6])); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> sts_q[BIT_CE]); // R4
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt && !ue_evt && (sts_q[BIT_CE] || sts_q[BIT_UE])) |=> $stable(cap_blk)); // R6
    AST_UE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt && !sts_q[BIT_UE]) |=> (cap_blk == $past(ue_blk))); // R7
    AST_UE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt && sts_q[BIT_UE]) |=> $stable(cap_blk)); // R8
    AST_SERR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o == $past((sts_q[BIT_CE] && cmd_q[EN_CE]) || (sts_q[BIT_UE] && cmd_q[EN_UE]))); // R11
endmodule

bind ecc_err_capture ecc_cap_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_evt   (ce_evt),
    .ue_evt   (ue_evt),
    .ue_blk   (ue_blk),
    .sts_q    (sts_q),
    .cmd_q    (cmd_q),
    .cap_blk  (cap_blk),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .serr_o   (serr_o)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 0, ue_evt = 0, ce_chan = 0, ue_chan = 0;
    logic [19:0] ce_blk = '0, ue_blk = '0;
    logic [7:0]  ce_syn = '0, ue_syn = '0;
    logic [6:0]  aux_evt = '0;
    logic        reg_wen = 0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference
    logic [15:0] m_sts, m_cmd;
    logic [31:0] m_addr;
    logic [7:0]  m_syn;
    logic        m_chan, m_serr;

    always #2.5 clk = ~clk;

    ecc_err_capture u_ecc_err_capture (
        .clk(clk), .rst_n(rst_n),
        .ce_evt(ce_evt), .ce_blk(ce_blk), .ce_syn(ce_syn), .ce_chan(ce_chan),
        .ue_evt(ue_evt), .ue_blk(ue_blk), .ue_syn(ue_syn), .ue_chan(ue_chan),
        .aux_evt(aux_evt), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr_o(serr_o)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h58: return m_addr;
            8'h5C: return {24'd0, m_syn};
            8'h5D: return {31'd0, m_chan};
            8'hC8: return {16'd0, m_sts};
            8'hCA: return {16'd0, m_cmd};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic nserr;
        logic ce_p, ue_p;
        if (!rst_n) begin
            m_sts = 0; m_cmd = 0; m_addr = 0; m_syn = 0; m_chan = 0; m_serr = 0;
        end else begin
            ce_p  = m_sts[0];
            ue_p  = m_sts[7];
            nserr = (m_sts[0] && m_cmd[7]) || (m_sts[7] && m_cmd[8]);
            if (ue_evt && !ue_p) begin
                m_addr = {ue_blk, 12'd0}; m_syn = ue_syn; m_chan = ue_chan;
            end else if (ce_evt && !ue_evt && !ce_p && !ue_p) begin
                m_addr = {ce_blk, 12'd0}; m_syn = ce_syn; m_chan = ce_chan;
            end
            if (reg_wen && reg_addr == 8'hC8) m_sts = m_sts & ~reg_wdata;
            if (reg_wen && reg_addr == 8'hCA) m_cmd = reg_wdata & 16'h03FE;
            if (ce_evt) m_sts[0] = 1'b1;
            if (ue_evt) m_sts[7] = 1'b1;
            for (int i = 0; i < 7; i++)
                if (aux_evt[i]) m_sts[(i < 5) ? i + 1 : i + 3] = 1'b1;
            m_serr = nserr;
        end
        #1;
        if (!done) begin
            checks++;
            if (serr_o !== m_serr) begin
                errors++;
                $display("FAIL R11 model serr: actual=%0b expected=%0b", serr_o, m_serr);
            end
            checks++;
            if (reg_rdata !== m_read(reg_addr)) begin
                errors++;
                $display("FAIL R12 model read @%h: actual=%h expected=%h",
                         reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read @%h: actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_serr(input logic exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (serr_o !== exp) begin
            errors++;
            $display("FAIL %s serr: actual=%0b expected=%0b", tag, serr_o, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 0;
    endtask

    task automatic pulse(input logic ce, input logic [19:0] cb, input logic [7:0] cs,
                         input logic cc, input logic ue, input logic [19:0] ub,
                         input logic [7:0] us, input logic uc);
        @(negedge clk);
        ce_evt = ce; ce_blk = cb; ce_syn = cs; ce_chan = cc;
        ue_evt = ue; ue_blk = ub; ue_syn = us; ue_chan = uc;
        @(negedge clk);
        ce_evt = 0; ue_evt = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_rd(8'h58, 0, "R1"); chk_rd(8'h5C, 0, "R1"); chk_rd(8'h5D, 0, "R1");
        chk_rd(8'hC8, 0, "R1"); chk_rd(8'hCA, 0, "R1"); chk_serr(0, "R1");
        // R10 command writable bits
        wr(8'hCA, 16'hFFFF);
        chk_rd(8'hCA, 32'h03FE, "R10");
        // R5 first correctable capture, R9 layout
        pulse(1, 20'h12345, 8'hA5, 1, 0, 0, 0, 0);
        chk_rd(8'h58, 32'h1234_5000, "R9");
        chk_rd(8'h5C, 32'hA5, "R5");
        chk_rd(8'h5D, 32'h1, "R5");
        chk_rd(8'hC8, 32'h0001, "R2");
        chk_serr(1, "R11");
        // R6 second correctable keeps record
        pulse(1, 20'hDEADB, 8'h11, 0, 0, 0, 0, 0);
        chk_rd(8'h58, 32'h1234_5000, "R6");
        chk_rd(8'h5C, 32'hA5, "R6");
        // R7 uncorrectable overwrites pending correctable
        pulse(0, 0, 0, 0, 1, 20'h80000, 8'h3C, 0);
        chk_rd(8'h58, 32'h8000_0000, "R7");
        chk_rd(8'h5C, 32'h3C, "R7");
        chk_rd(8'h5D, 32'h0, "R7");
        chk_rd(8'hC8, 32'h0081, "R7");
        // R8 second uncorrectable keeps record
        pulse(0, 0, 0, 0, 1, 20'h00001, 8'hEE, 1);
        chk_rd(8'h58, 32'h8000_0000, "R8");
        chk_rd(8'h5C, 32'h3C, "R8");
        // R3 write-one-to-clear
        wr(8'hC8, 16'h0080);
        chk_rd(8'hC8, 32'h0001, "R3");
        wr(8'hC8, 16'h0081);
        chk_rd(8'hC8, 32'h0000, "R3");
        chk_serr(0, "R11");
        // R4 event beats clear in same cycle
        @(negedge clk);
        reg_wen = 1; reg_addr = 8'hC8; reg_wdata = 16'h0001;
        ce_evt = 1; ce_blk = 20'h0ABCD; ce_syn = 8'h5A; ce_chan = 0;
        @(negedge clk);
        reg_wen = 0; ce_evt = 0;
        chk_rd(8'hC8, 32'h0001, "R4");
        chk_rd(8'h58, 32'h0ABC_D000, "R4");
        wr(8'hC8, 16'h0081);
        // R7 simultaneous events keep uncorrectable details
        pulse(1, 20'h11111, 8'h22, 0, 1, 20'h22222, 8'h77, 1);
        chk_rd(8'h58, 32'h2222_2000, "R7");
        chk_rd(8'h5C, 32'h77, "R7");
        chk_rd(8'h5D, 32'h1, "R7");
        wr(8'hC8, 16'h0081);
        // R2 non-ECC flags
        @(negedge clk); aux_evt = 7'h7F;
        @(negedge clk); aux_evt = 0;
        chk_rd(8'hC8, 32'h033E, "R2");
        wr(8'hC8, 16'hFFFF);
        chk_rd(8'hC8, 32'h0000, "R3");
        // R12 writes elsewhere ignored, unmapped reads zero
        wr(8'h58, 16'hFFFF); wr(8'h5C, 16'hFFFF); wr(8'h5D, 16'hFFFF); wr(8'h00, 16'hFFFF);
        chk_rd(8'h58, 32'h2222_2000, "R12");
        chk_rd(8'h5C, 32'h77, "R12");
        chk_rd(8'h5D, 32'h1, "R12");
        chk_rd(8'hCA, 32'h03FE, "R12");
        chk_rd(8'h00, 32'h0, "R12");
        chk_rd(8'h59, 32'h0, "R12");
        // R11 enables gate serr
        wr(8'hCA, 16'h0000);
        pulse(1, 20'h00042, 8'h01, 0, 0, 0, 0, 0);
        chk_serr(0, "R11");
        chk_serr(0, "R11");
        wr(8'hCA, 16'h0080);
        chk_serr(1, "R11");
        wr(8'hCA, 16'h0100);
        chk_serr(0, "R11");
        pulse(0, 0, 0, 0, 1, 20'h00043, 8'h02, 0);
        chk_serr(1, "R11");
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule